// File: doc/BRIEF.md
# Host Wake-Command-Response Sequencer

This block runs one complete host-side transaction with a single-wire authentication device. After a start pulse it wakes the device and confirms the wake-up by the reply byte 0x11. It then issues the command flag and hands off a command block. It waits a programmable number of cycles for parsing and execution and collects the response frame. An external checker verifies the frame CRC, and the block always closes by putting the device back to sleep. The line-level bit timing, the flag byte values and the CRC arithmetic sit in neighbouring blocks. This block talks to them through three request/acknowledge pairs: a flag sender, a block sender and a frame checker.

A command-type input picks one of two paths. The long path polls the device once after the parse delay, so that a format error can be caught before the long execution wait. The short path waits the parse and execution delays back to back in one stretch. A frame that fails its check is asked for again by resending only the transmit flag, up to a parameterised number of times. Received frame bytes are stored and stay readable through a random-access read port until the next frame begins.

Top module: `auth_txn_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `flag_req`, `blk_req` and `chk_req` are low, and `status` is 0 (OK). While `busy` is low no request output is raised.
- R2: A transaction first sends flag code 0 (wake) and then flag code 1 (transmit). A first received byte of 0x11 leads to flag code 2 (command) and then a block-send request. Any other byte ends the transaction with status 1 (wake error), and that byte appears on `err_code`.
- R3: When `cmd_long` is 1 at start, the transmit flag request appears exactly `parse_cycles`+1 cycles after the cycle in which the block-send handshake completes. A byte received in the following listen window ends the transaction with status 2 (format error), and that byte appears on `err_code`.
- R4: On the long path, if the poll gets no byte, the next transmit flag request appears exactly `rx_timeout`+`exec_cycles`+2 cycles after the poll flag is acknowledged.
- R5: When `cmd_long` is 0, the read transmit flag request appears exactly `parse_cycles`+`exec_cycles`+1 cycles after the block-send handshake completes, and no poll flag is sent.
- R6: The first byte of a response frame is its total length (4 to MAX_BLK). The bytes are stored at addresses 0 upward and read back on `rd_data` for `rd_addr`. `resp_len` counts them, and `chk_req` rises once the counted length has arrived.
- R7: A length byte outside 4..MAX_BLK ends that attempt as a failed one at once, without a checker request.
- R8: A failed attempt (checker reports fail, or R7) resends only the transmit flag and collects a new frame. This repeats up to MAX_RETRY (default 3) retries. The attempt after the last retry that fails ends with status 3 (CRC error).
- R9: In a wake or frame wait, a byte must arrive within `rx_timeout`+1 cycles of the wait's start or of the previous byte. Otherwise the transaction ends with status 4 (timeout).
- R10: Every transaction, whatever its outcome, ends with flag code 3 (sleep), followed by a `done` pulse of one cycle. `status` holds its value from `done` until the next accepted start. A frame that passes the check gives status 0.
- R11: `flag_req` stays high with a stable `flag_code` until `flag_ack`. At most one of `flag_req`, `blk_req` and `chk_req` is high at a time.
- R12: A `start` pulse while `busy` is high has no effect on the flag sequence or the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transaction (taken when idle) |
| cmd_long | input | 1 | 1 selects the long path with a parse poll |
| parse_cycles | input | DLY_W | Parse delay in cycles, stable while busy |
| exec_cycles | input | DLY_W | Execution delay in cycles, stable while busy |
| rx_timeout | input | DLY_W | Receive timeout window in cycles, stable while busy |
| flag_req | output | 1 | Flag-send request |
| flag_code | output | 2 | 0 wake, 1 transmit, 2 command, 3 sleep |
| flag_ack | input | 1 | Flag sender accepted the flag |
| blk_req | output | 1 | Command-block send request |
| blk_done | input | 1 | Command block has been sent |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| chk_req | output | 1 | Ask the external checker to judge the frame |
| chk_done | input | 1 | Checker result present |
| chk_pass | input | 1 | Checker result: frame good |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| status | output | 3 | 0 OK, 1 wake error, 2 format error, 3 CRC error, 4 timeout |
| err_code | output | 8 | Byte that caused a wake or format error |
| resp_len | output | AW | Number of stored frame bytes |
| rd_addr | input | AW | Read address into the frame store |
| rd_data | output | 8 | Stored frame byte at `rd_addr` |

## Verification
The hardest state to reach is the last permitted retry: it takes a run of failing attempts, mixing checker rejections and bad length bytes, followed by either a pass or one more failure. The device model in the bench plays a per-attempt script, so that directed cases hit exactly MAX_RETRY and MAX_RETRY+1 failures and random cases draw the mixes. A second hard case is the exact cycle counts of the waits. The model timestamps every handshake and compares the gaps with counts it derives from the delay inputs.

// File: rtl/auth_seq_pkg.sv
// Package: shared encodings for the wake-command-response sequencer.
// Assumes: flag codes and status values are decoded by neighbouring blocks.
package auth_seq_pkg;

    typedef enum logic [1:0] {
        FLG_WAKE  = 2'd0,
        FLG_XMIT  = 2'd1,
        FLG_CMD   = 2'd2,
        FLG_SLEEP = 2'd3
    } flag_e;

    typedef enum logic [2:0] {
        TS_OK       = 3'd0,
        TS_WAKE_ERR = 3'd1,
        TS_FMT_ERR  = 3'd2,
        TS_CRC_ERR  = 3'd3,
        TS_TIMEOUT  = 3'd4
    } txn_status_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_F_WAKE,
        SQ_F_WXMIT,
        SQ_RX_WAKE,
        SQ_F_CMD,
        SQ_BLK,
        SQ_WAIT_PARSE,
        SQ_F_POLL,
        SQ_RX_POLL,
        SQ_WAIT_EXEC,
        SQ_F_READ,
        SQ_RX_BLK,
        SQ_CHECK,
        SQ_F_SLEEP,
        SQ_DONE
    } seq_state_e;

    localparam logic [7:0] WAKE_OK_BYTE = 8'h11;
    localparam int         MIN_FRAME    = 4;

endpackage

// File: rtl/seq_countdown.sv
// Module: seq_countdown
// Loadable down-counter shared by every wait of the sequencer.
// Assumes: the owner loads it on entry to a wait and polls zero each cycle;
// a loaded value V reaches zero V cycles later and then holds there.
module seq_countdown #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Load a new count or step down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expired flag.
    always_comb zero = (cnt_q == '0);

endmodule

// File: rtl/seq_rx_frame.sv
// Module: seq_rx_frame
// Collects one response frame: the first byte is the total length, the
// rest follow. Flags the frame complete or its length byte out of range,
// and offers the stored bytes on a read port.
// Assumes: clear precedes every frame; no byte is taken once full or bad.
module seq_rx_frame
    import auth_seq_pkg::*;
#(
    parameter int MAX_BLK = 39,
    parameter int AW      = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    output logic          full,
    output logic          bad,
    output logic [AW-1:0] len,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [AW-1:0] idx_q;
    logic [7:0]    need_q;
    logic          full_q;
    logic          bad_q;
    logic          take;
    logic [7:0]    store_q [MAX_BLK];

    // A byte is accepted only while collecting and not yet finished.
    always_comb take = en && rx_valid && !full_q && !bad_q;

    // Track position, announced length, completion and range fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            need_q <= '0;
            full_q <= 1'b0;
            bad_q  <= 1'b0;
        end else if (clear) begin
            idx_q  <= '0;
            need_q <= '0;
            full_q <= 1'b0;
            bad_q  <= 1'b0;
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == '0) begin
                need_q <= rx_byte;
                bad_q  <= (rx_byte < 8'(MIN_FRAME)) || (rx_byte > 8'(MAX_BLK));
            end else begin
                full_q <= ((8'(idx_q) + 8'd1) == need_q);
            end
        end
    end

    // Byte storage, written in arrival order.
    always_ff @(posedge clk) begin
        if (take) begin
            store_q[idx_q] <= rx_byte;
        end
    end

    // Read port and status outputs.
    always_comb begin
        rd_data = (rd_addr < AW'(MAX_BLK)) ? store_q[rd_addr] : 8'h00;
        full    = full_q;
        bad     = bad_q;
        len     = idx_q;
    end

endmodule

// File: rtl/seq_ctrl.sv
// Module: seq_ctrl
// Transaction state machine: wake handshake, command issue, parse/exec
// waits (long or short path), frame collection with bounded retries, and
// the closing sleep flag. Drives a shared countdown for every wait.
// Assumes: delay inputs are stable while busy; handshake partners hold
// their done/ack for one cycle per request.
module seq_ctrl
    import auth_seq_pkg::*;
#(
    parameter int DLY_W     = 16,
    parameter int MAX_RETRY = 3,
    localparam int TW       = DLY_W + 1,
    localparam int RC_W     = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmd_long,
    input  logic [DLY_W-1:0] parse_cycles,
    input  logic [DLY_W-1:0] exec_cycles,
    input  logic [DLY_W-1:0] rx_timeout,
    output logic             flag_req,
    output logic [1:0]       flag_code,
    input  logic             flag_ack,
    output logic             blk_req,
    input  logic             blk_done,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             chk_req,
    input  logic             chk_done,
    input  logic             chk_pass,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [TW-1:0]    tmr_val,
    output logic             frm_clear,
    output logic             frm_en,
    input  logic             frm_full,
    input  logic             frm_bad,
    output logic             busy,
    output logic             done,
    output logic [2:0]       status,
    output logic [7:0]       err_code
);

    seq_state_e  state_q, state_d;
    txn_status_e status_q, status_d;
    logic        set_status;
    logic        set_err;
    logic [RC_W-1:0] retry_q;
    logic        retry_inc;
    logic        retry_clr;
    logic        long_q;
    logic [7:0]  err_q;

    // Failed-attempt outcome: another read or give up.
    function automatic seq_state_e after_fail(input logic [RC_W-1:0] tries);
        return (tries < RC_W'(MAX_RETRY)) ? SQ_F_READ : SQ_F_SLEEP;
    endfunction

    // Next-state, timer loads and outcome decisions.
    always_comb begin
        state_d    = state_q;
        status_d   = status_q;
        set_status = 1'b0;
        set_err    = 1'b0;
        retry_inc  = 1'b0;
        retry_clr  = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        frm_clear  = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (start) begin
                    state_d    = SQ_F_WAKE;
                    retry_clr  = 1'b1;
                    set_status = 1'b1;
                    status_d   = TS_OK;
                end
            end
            SQ_F_WAKE: begin
                if (flag_ack) state_d = SQ_F_WXMIT;
            end
            SQ_F_WXMIT: begin
                if (flag_ack) begin
                    state_d  = SQ_RX_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(rx_timeout);
                end
            end
            SQ_RX_WAKE: begin
                if (rx_valid) begin
                    if (rx_byte == WAKE_OK_BYTE) begin
                        state_d = SQ_F_CMD;
                    end else begin
                        state_d    = SQ_F_SLEEP;
                        set_status = 1'b1;
                        status_d   = TS_WAKE_ERR;
                        set_err    = 1'b1;
                    end
                end else if (tmr_zero) begin
                    state_d    = SQ_F_SLEEP;
                    set_status = 1'b1;
                    status_d   = TS_TIMEOUT;
                end
            end
            SQ_F_CMD: begin
                if (flag_ack) state_d = SQ_BLK;
            end
            SQ_BLK: begin
                if (blk_done) begin
                    tmr_load = 1'b1;
                    if (long_q) begin
                        state_d = SQ_WAIT_PARSE;
                        tmr_val = TW'(parse_cycles);
                    end else begin
                        state_d = SQ_WAIT_EXEC;
                        tmr_val = TW'(parse_cycles) + TW'(exec_cycles);
                    end
                end
            end
            SQ_WAIT_PARSE: begin
                if (tmr_zero) state_d = SQ_F_POLL;
            end
            SQ_F_POLL: begin
                if (flag_ack) begin
                    state_d  = SQ_RX_POLL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(rx_timeout);
                end
            end
            SQ_RX_POLL: begin
                if (rx_valid) begin
                    state_d    = SQ_F_SLEEP;
                    set_status = 1'b1;
                    status_d   = TS_FMT_ERR;
                    set_err    = 1'b1;
                end else if (tmr_zero) begin
                    state_d  = SQ_WAIT_EXEC;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(exec_cycles);
                end
            end
            SQ_WAIT_EXEC: begin
                if (tmr_zero) state_d = SQ_F_READ;
            end
            SQ_F_READ: begin
                if (flag_ack) begin
                    state_d   = SQ_RX_BLK;
                    frm_clear = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(rx_timeout);
                end
            end
            SQ_RX_BLK: begin
                if (frm_bad) begin
                    state_d   = after_fail(retry_q);
                    retry_inc = 1'b1;
                    if (state_d == SQ_F_SLEEP) begin
                        set_status = 1'b1;
                        status_d   = TS_CRC_ERR;
                    end
                end else if (frm_full) begin
                    state_d = SQ_CHECK;
                end else if (rx_valid) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(rx_timeout);
                end else if (tmr_zero) begin
                    state_d    = SQ_F_SLEEP;
                    set_status = 1'b1;
                    status_d   = TS_TIMEOUT;
                end
            end
            SQ_CHECK: begin
                if (chk_done) begin
                    if (chk_pass) begin
                        state_d    = SQ_F_SLEEP;
                        set_status = 1'b1;
                        status_d   = TS_OK;
                    end else begin
                        state_d   = after_fail(retry_q);
                        retry_inc = 1'b1;
                        if (state_d == SQ_F_SLEEP) begin
                            set_status = 1'b1;
                            status_d   = TS_CRC_ERR;
                        end
                    end
                end
            end
            SQ_F_SLEEP: begin
                if (flag_ack) state_d = SQ_DONE;
            end
            SQ_DONE: begin
                state_d = SQ_IDLE;
            end
            default: begin
                state_d = SQ_IDLE;
            end
        endcase
    end

    // State, outcome, error byte, path choice and retry count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            status_q <= TS_OK;
            err_q    <= 8'h00;
            long_q   <= 1'b0;
            retry_q  <= '0;
        end else begin
            state_q <= state_d;
            if (set_status) status_q <= status_d;
            if (set_err) err_q <= rx_byte;
            if (state_q == SQ_IDLE && start) long_q <= cmd_long;
            if (retry_clr) begin
                retry_q <= '0;
            end else if (retry_inc && retry_q < RC_W'(MAX_RETRY)) begin
                retry_q <= retry_q + 1'b1;
            end
        end
    end

    // Flag request and code decoded from the flag states.
    always_comb begin
        flag_req  = 1'b1;
        flag_code = FLG_XMIT;
        unique case (state_q)
            SQ_F_WAKE:  flag_code = FLG_WAKE;
            SQ_F_WXMIT, SQ_F_POLL, SQ_F_READ: flag_code = FLG_XMIT;
            SQ_F_CMD:   flag_code = FLG_CMD;
            SQ_F_SLEEP: flag_code = FLG_SLEEP;
            default:    flag_req  = 1'b0;
        endcase
    end

    // Remaining handshake and status outputs.
    always_comb begin
        blk_req  = (state_q == SQ_BLK);
        chk_req  = (state_q == SQ_CHECK);
        frm_en   = (state_q == SQ_RX_BLK);
        busy     = (state_q != SQ_IDLE);
        done     = (state_q == SQ_DONE);
        status   = status_q;
        err_code = err_q;
    end

endmodule

// File: rtl/auth_txn_seq.sv
// Module: auth_txn_seq (top)
// Host sequencer for one wake-command-response transaction with a
// single-wire authentication device. Wires the state machine, the shared
// wait counter and the frame collector together.
// Assumes: flag, block and checker partners follow a request/acknowledge
// handshake; the checker observes the received bytes on its own.
module auth_txn_seq
    import auth_seq_pkg::*;
#(
    parameter int DLY_W     = 16,
    parameter int MAX_RETRY = 3,
    parameter int MAX_BLK   = 39,
    localparam int AW       = $clog2(MAX_BLK + 1),
    localparam int TW       = DLY_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmd_long,
    input  logic [DLY_W-1:0] parse_cycles,
    input  logic [DLY_W-1:0] exec_cycles,
    input  logic [DLY_W-1:0] rx_timeout,
    output logic             flag_req,
    output logic [1:0]       flag_code,
    input  logic             flag_ack,
    output logic             blk_req,
    input  logic             blk_done,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             chk_req,
    input  logic             chk_done,
    input  logic             chk_pass,
    output logic             busy,
    output logic             done,
    output logic [2:0]       status,
    output logic [7:0]       err_code,
    output logic [AW-1:0]    resp_len,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data
);

    logic          tmr_zero;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          frm_clear;
    logic          frm_en;
    logic          frm_full;
    logic          frm_bad;

    seq_ctrl #(
        .DLY_W     (DLY_W),
        .MAX_RETRY (MAX_RETRY)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cmd_long     (cmd_long),
        .parse_cycles (parse_cycles),
        .exec_cycles  (exec_cycles),
        .rx_timeout   (rx_timeout),
        .flag_req     (flag_req),
        .flag_code    (flag_code),
        .flag_ack     (flag_ack),
        .blk_req      (blk_req),
        .blk_done     (blk_done),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .chk_req      (chk_req),
        .chk_done     (chk_done),
        .chk_pass     (chk_pass),
        .tmr_zero     (tmr_zero),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .frm_clear    (frm_clear),
        .frm_en       (frm_en),
        .frm_full     (frm_full),
        .frm_bad      (frm_bad),
        .busy         (busy),
        .done         (done),
        .status       (status),
        .err_code     (err_code)
    );

    seq_countdown #(
        .W (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    seq_rx_frame #(
        .MAX_BLK (MAX_BLK),
        .AW      (AW)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frm_clear),
        .en       (frm_en),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .full     (frm_full),
        .bad      (frm_bad),
        .len      (resp_len),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/auth_txn_seq_chk.sv
// Module: auth_txn_seq_chk
// Protocol checker bound to the sequencer top: handshake holding, request
// exclusivity, idle quietness, frame-length floor and sleep-before-done.
module auth_txn_seq_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          flag_req,
    input logic          flag_ack,
    input logic [1:0]    flag_code,
    input logic          blk_req,
    input logic          chk_req,
    input logic [AW-1:0] resp_len
);

    logic slept_q;

    // Remember whether the sleep flag has been accepted in this transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slept_q <= 1'b0;
        end else if (start && !busy) begin
            slept_q <= 1'b0;
        end else if (flag_req && flag_ack && flag_code == 2'd3) begin
            slept_q <= 1'b1;
        end
    end

    // R1: nothing is requested while idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(flag_req || blk_req || chk_req));

    // R11: flag request holds its code until acknowledged.
    a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_req && !flag_ack) |=> (flag_req && $stable(flag_code)));

    // R11: at most one request type at a time.
    a_r11_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({flag_req, blk_req, chk_req}) <= 1);

    // R6: the checker is only asked for a frame of legal minimum size.
    a_r6_frame_floor: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |-> (resp_len >= AW'(4)));

    // R10: done follows an accepted sleep flag.
    a_r10_sleep_first: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> slept_q);

    // R10: done lasts one cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind auth_txn_seq auth_txn_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .flag_req  (flag_req),
    .flag_ack  (flag_ack),
    .flag_code (flag_code),
    .blk_req   (blk_req),
    .chk_req   (chk_req),
    .resp_len  (resp_len)
);

// File: tb/auth_txn_seq_test.sv
// Bench for auth_txn_seq: a scripted device model answers every flag,
// block and check request; expected outcomes come from bench functions.
module auth_txn_seq_test;

    localparam int DLY_W = 16;
    localparam int MAXR  = 3;
    localparam int MAXB  = 39;
    localparam int AW    = $clog2(MAXB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmd_long = 1'b0;
    logic [DLY_W-1:0] parse_c = '0, exec_c = '0, rxto_c = 16'd10;
    logic flag_req, flag_ack = 1'b0;
    logic [1:0] flag_code;
    logic blk_req, blk_done = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic chk_req, chk_done = 1'b0, chk_pass = 1'b0;
    logic busy, done;
    logic [2:0] status;
    logic [7:0] err_code;
    logic [AW-1:0] resp_len;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_cmp = 0, n_bad = 0, cyc = 0;

    // Device script for the current transaction.
    int sc_wake, sc_poll;
    int sc_kind [8];
    int sc_len  [8];
    logic [7:0] fr [8][40];
    int txn_id = 0;

    // Observations recorded by the device model.
    int nflag, blk_acc, gap1, gap2, poll_seen, cur_att;
    logic [1:0] flog [16];

    // Expected results.
    int exp_n, exp_status, exp_err, exp_last;
    logic [1:0] eflog [16];

    auth_txn_seq #(.DLY_W(DLY_W), .MAX_RETRY(MAXR), .MAX_BLK(MAXB)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_long(cmd_long),
        .parse_cycles(parse_c), .exec_cycles(exec_c), .rx_timeout(rxto_c),
        .flag_req(flag_req), .flag_code(flag_code), .flag_ack(flag_ack),
        .blk_req(blk_req), .blk_done(blk_done), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .chk_req(chk_req), .chk_done(chk_done),
        .chk_pass(chk_pass), .busy(busy), .done(done), .status(status),
        .err_code(err_code), .resp_len(resp_len), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Device model: acknowledges requests and plays the script.
    initial begin : device
        logic [7:0] txq [64];
        int tq_n, tq_rd, tx_gap, seen_id, nx;
        tq_n = 0; tq_rd = 0; tx_gap = 0; seen_id = 0; nx = 0;
        forever begin
            @(negedge clk);
            if (seen_id != txn_id) begin
                seen_id = txn_id; nx = 0; tq_n = 0; tq_rd = 0;
                nflag = 0; gap1 = -1; gap2 = -1; blk_acc = -1; poll_seen = -1; cur_att = 0;
            end
            rx_valid = 1'b0;
            if (tq_rd < tq_n) begin
                if (tx_gap > 0) tx_gap--;
                else begin
                    rx_valid = 1'b1; rx_byte = txq[tq_rd]; tq_rd++;
                    tx_gap = int'($urandom % 3);
                end
            end
            if (blk_done) blk_done = 1'b0;
            else if (blk_req) begin blk_done = 1'b1; blk_acc = cyc + 1; end
            if (chk_done) chk_done = 1'b0;
            else if (chk_req) begin chk_done = 1'b1; chk_pass = (sc_kind[cur_att] == 0); end
            if (flag_ack) flag_ack = 1'b0;
            else if (flag_req) begin
                flag_ack = 1'b1;
                if (nflag < 16) flog[nflag] = flag_code;
                nflag++;
                if (flag_code == 2'd1) begin
                    tq_n = 0; tq_rd = 0; tx_gap = 1 + int'($urandom % 2);
                    if (nx == 0) begin
                        if (sc_wake >= 0) begin txq[0] = 8'(sc_wake); tq_n = 1; end
                    end else if (cmd_long && nx == 1) begin
                        gap1 = cyc - blk_acc; poll_seen = cyc;
                        if (sc_poll >= 0) begin txq[0] = 8'(sc_poll); tq_n = 1; end
                    end else begin
                        cur_att = nx - (cmd_long ? 2 : 1);
                        if (cur_att == 0) begin
                            if (cmd_long) gap2 = cyc - (poll_seen + 1);
                            else gap1 = cyc - blk_acc;
                        end
                        if (sc_kind[cur_att] == 2) begin txq[0] = 8'd2; tq_n = 1; end
                        else if (sc_kind[cur_att] != 3) begin
                            for (int i = 0; i < sc_len[cur_att]; i++) txq[i] = fr[cur_att][i];
                            tq_n = sc_len[cur_att];
                        end
                    end
                    nx++;
                end
            end
        end
    end

    function automatic void epush(input int c);
        eflog[exp_n] = 2'(c); exp_n++;
    endfunction

    // Expected flag sequence and outcome from the script (R2..R10).
    function automatic void build_expect();
        exp_n = 0; exp_err = -1; exp_last = -1;
        epush(0); epush(1);
        if (sc_wake < 0) begin exp_status = 4; epush(3); return; end
        if (sc_wake != 8'h11) begin exp_status = 1; exp_err = sc_wake; epush(3); return; end
        epush(2);
        if (cmd_long) begin
            epush(1);
            if (sc_poll >= 0) begin exp_status = 2; exp_err = sc_poll; epush(3); return; end
        end
        for (int a = 0; a <= MAXR; a++) begin
            epush(1);
            if (sc_kind[a] == 3) begin exp_status = 4; epush(3); return; end
            if (sc_kind[a] == 0) begin exp_status = 0; exp_last = a; epush(3); return; end
            if (a == MAXR) begin exp_status = 3; epush(3); return; end
        end
    endfunction

    function automatic void make_frames();
        for (int a = 0; a < 8; a++) begin
            sc_len[a] = 4 + int'($urandom % (MAXB - 3));
            fr[a][0] = 8'(sc_len[a]);
            for (int i = 1; i < 40; i++) fr[a][i] = 8'($urandom);
        end
    endfunction

    task automatic run_txn(input bit mid_start);
        int wd, ok;
        build_expect();
        txn_id++;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (mid_start) begin
            repeat (3) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        wd = 0;
        while (!done && wd < 6000) begin @(negedge clk); wd++; end
        if (!done) begin
            check("R10 watchdog", 0, 1);
            return;
        end
        check("R10 status at done", int'(status), exp_status);
        ok = (nflag == exp_n);
        for (int i = 0; i < exp_n && i < 16; i++) if (flog[i] != eflog[i]) ok = 0;
        check(mid_start ? "R12 flag sequence with start while busy" : "R2 R8 R10 flag sequence", ok, 1);
        if (exp_err >= 0) check("R2 R3 err_code", int'(err_code), exp_err);
        if (exp_n >= 5 && exp_status != 1) begin
            if (cmd_long) check("R3 parse gap", gap1, int'(parse_c) + 1);
            else check("R5 short wait gap", gap1, int'(parse_c) + int'(exec_c) + 1);
        end
        if (cmd_long && gap2 >= 0)
            check("R4 exec gap", gap2, int'(rxto_c) + int'(exec_c) + 2);
        if (exp_status == 0) begin
            check("R6 resp_len", int'(resp_len), sc_len[exp_last]);
            ok = 1;
            for (int i = 0; i < sc_len[exp_last]; i++) begin
                rd_addr = AW'(i); #1;
                if (rd_data != fr[exp_last][i]) ok = 0;
            end
            check("R6 stored bytes", ok, 1);
        end
        @(negedge clk);
        check("R10 done one cycle", int'(done), 0);
        check("R10 idle after done", int'(busy), 0);
        check("R10 status held", int'(status), exp_status);
    endtask

    task automatic setup(input bit lng, input int p, input int e, input int t,
                         input int wk, input int pl,
                         input int k0, input int k1, input int k2, input int k3);
        cmd_long = lng; parse_c = 16'(p); exec_c = 16'(e); rxto_c = 16'(t);
        sc_wake = wk; sc_poll = pl;
        sc_kind[0] = k0; sc_kind[1] = k1; sc_kind[2] = k2; sc_kind[3] = k3;
        make_frames();
    endtask

    initial begin : main
        void'($urandom(32'h5eed_0042));
        for (int a = 0; a < 8; a++) sc_kind[a] = 0;
        sc_wake = 8'h11; sc_poll = -1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 requests", int'(flag_req | blk_req | chk_req), 0);
        check("R1 status", int'(status), 0);

        setup(0, 5, 7, 10, 8'h11, -1, 0, 0, 0, 0); run_txn(0);   // R5 short OK
        setup(1, 4, 9, 10, 8'h11, -1, 0, 0, 0, 0); run_txn(0);   // R3 R4 long OK
        setup(1, 0, 0, 8, 8'h11, -1, 0, 0, 0, 0);  run_txn(0);   // R3 zero delays
        setup(0, 3, 3, 10, 8'h5a, -1, 0, 0, 0, 0); run_txn(0);   // R2 wake error
        setup(0, 3, 3, 10, -1, -1, 0, 0, 0, 0);    run_txn(0);   // R9 wake timeout
        setup(1, 6, 2, 10, 8'h11, 8'h03, 0, 0, 0, 0); run_txn(0); // R3 format error
        setup(0, 2, 2, 9, 8'h11, -1, 1, 1, 1, 0);  run_txn(0);   // R8 last retry passes
        setup(0, 2, 2, 9, 8'h11, -1, 1, 2, 1, 1);  run_txn(0);   // R8 retries exhausted
        setup(1, 2, 2, 9, 8'h11, -1, 2, 0, 0, 0);  run_txn(0);   // R7 bad length then OK
        setup(0, 2, 2, 9, 8'h11, -1, 1, 3, 0, 0);  run_txn(0);   // R9 frame timeout
        setup(1, 3, 4, 12, 8'h11, -1, 0, 0, 0, 0); run_txn(1);   // R12 start while busy

        for (int n = 0; n < 40; n++) begin
            int r;
            cmd_long = 1'($urandom);
            parse_c = 16'($urandom % 21); exec_c = 16'($urandom % 31);
            rxto_c = 16'(8 + $urandom % 13);
            r = int'($urandom % 20);
            sc_wake = (r == 0) ? -1 : (r == 1) ? 8'h22 : 8'h11;
            sc_poll = ($urandom % 5 == 0) ? int'($urandom % 256) : -1;
            for (int a = 0; a < 8; a++) begin
                r = int'($urandom % 10);
                sc_kind[a] = (r < 6) ? 0 : (r < 8) ? 1 : (r < 9) ? 2 : 3;
            end
            make_frames();
            run_txn(n % 7 == 3);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Global watchdog: counts as a failed check and still summarises.
    initial begin : watchdog
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL R10 global watchdog expired: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule